// File: doc/BRIEF.md
# Dual-Bank Micro-Op Dispatcher

This block accepts one micro-operation at a time and runs it against two operand banks, called low and high. Every bank slot holds a multi-word field element, and the block moves that element one word per cycle. A micro-op can copy an element between any pair of bank slots, run two such copies back to back, fill a slot from an external word-group memory, or write a slot out to that memory. It can also ask an external modular arithmetic engine to add, subtract or multiply two elements, using either p or 2p as the modulus.

The banks, the external memory and the arithmetic engine all sit outside the block. The dispatcher produces the read and write addresses, the word indices and the strobes. In a compute op it streams the operand pairs to the engine, then writes the result words back as the engine returns them. The two lowest slots of each bank hold the constants zero and one, and nothing can overwrite them.

Top module: `uop_dispatch`

## Requirements
- R1: During reset and directly after it, `uopReady` is 1, and `wrEn`, `memWrEn`, `engOpValid` and `uopErr` are 0. A reset in the middle of an op abandons that op and brings `uopReady` back to 1.
- R2: Encodings. Bank: low = 0, high = 1. Slots: 0 = zero constant, 1 = one constant, 2 = R1, 3 = R2, 4 = T_1, 5 = T_10, 6 = T_1001, 7 = T_1011, 8 = T_X5, 9 = T_X10, 10 = T_X20, 11 = T_X40, 12 = T_X50, 13 = T_X100. Op kind: move = 0, dual move = 1, load = 2, store = 3, compute = 4. Math: add = 0, sub = 1, mul = 2. Modulus: p = 0, 2p = 1.
- R3: A move copies source bank/slot A to destination bank/slot A, one word per cycle. It holds `uopReady` low for exactly WORDS cycles.
- R4: A dual move first copies source slot A to destination slot A, then copies source slot B to destination slot B. Both copies use the same source bank and the same destination bank. The second copy reads the contents left by the first. `uopReady` stays low for 2*WORDS cycles.
- R5: A load writes external memory word i into word i of the destination bank/slot A. `uopReady` stays low for WORDS cycles.
- R6: A store puts word i of source bank/slot A on the external memory write port as word i and writes no bank. `uopReady` stays low for WORDS cycles.
- R7: A compute op sends the engine the word pairs of source slots A and B, both from the source bank, together with the math code and the modulus select. It then writes each response word the engine returns into the destination bank/slot A.
- R8: `uopReady` goes low on the cycle after an op is accepted. It returns high only after the op's last write, so an op issued immediately afterwards reads the updated data.
- R9: Writes to slots 0 and 1 are suppressed. At acceptance, `uopErr` is set if the op is not a store and its destination A (or, for a dual move, either destination) is slot 0 or 1. `uopErr` then holds until the next op is accepted. The non-constant half of a dual move still takes place.
- R10: Words move in ascending order 0 to WORDS-1. `engFirst` is high only with operand word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uopValid | input | 1 | Micro-op offered |
| uopReady | output | 1 | Dispatcher idle, accepts op |
| uopKind | input | 3 | Op kind code |
| uopMath | input | 2 | Math code for compute |
| uopMod | input | 1 | Modulus select |
| uopSrcBank | input | 1 | Source bank |
| uopSrcA | input | SLOT_W | Source slot A |
| uopSrcB | input | SLOT_W | Source slot B |
| uopDstBank | input | 1 | Destination bank |
| uopDstA | input | SLOT_W | Destination slot A |
| uopDstB | input | SLOT_W | Destination slot B |
| uopErr | output | 1 | Constant-slot write attempted by last accepted op |
| rdBank | output | 1 | Bank read select |
| rdSlotA | output | SLOT_W | Bank read slot, port A |
| rdSlotB | output | SLOT_W | Bank read slot, port B |
| rdWord | output | WORD_W | Bank read word index |
| rdDataA | input | WIDTH | Bank read data, port A (combinational) |
| rdDataB | input | WIDTH | Bank read data, port B (combinational) |
| wrEn | output | 1 | Bank write strobe |
| wrBank | output | 1 | Bank write select |
| wrSlot | output | SLOT_W | Bank write slot |
| wrWord | output | WORD_W | Bank write word index |
| wrData | output | WIDTH | Bank write data |
| memRdWord | output | WORD_W | External memory read word index |
| memRdData | input | WIDTH | External memory read data (combinational) |
| memWrEn | output | 1 | External memory write strobe |
| memWrWord | output | WORD_W | External memory write word index |
| memWrData | output | WIDTH | External memory write data |
| engOpValid | output | 1 | Operand word pair valid |
| engFirst | output | 1 | Marks operand word 0 |
| engMath | output | 2 | Math code to engine |
| engMod | output | 1 | Modulus select to engine |
| engWord | output | WORD_W | Operand word index |
| engOpA | output | WIDTH | Operand A word |
| engOpB | output | WIDTH | Operand B word |
| engRspValid | input | 1 | Result word valid |
| engRspData | input | WIDTH | Result word |

## Verification
The checker watches every cycle for six things: no bank write to a constant slot, bank writes and engine traffic only while `uopReady` is low, `uopReady` dropping right after an accept, `uopErr` holding steady through a busy op, and a store never writing a bank. Only the scenarios can show the rest. They compare both banks against a reference after each op, which covers copy direction, the order of the two halves of a dual move, and load, store and compute results under each math code and modulus. They also measure the exact busy cycles per kind and check the ordering of the operand stream the stub engine receives.

// File: rtl/uop_pkg.sv
package uop_pkg;

  typedef enum logic [2:0] {
    K_MOVE  = 3'd0,
    K_MOVE2 = 3'd1,
    K_LOAD  = 3'd2,
    K_STORE = 3'd3,
    K_CALC  = 3'd4
  } kind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;     // latch the offered op
    logic cntClr;      // restart the word counter
    logic cntInc;      // advance the word counter
    logic second;      // second half of a dual move
    logic copyActive;  // word-serial copy phase
    logic sendActive;  // operand streaming phase
    logic rspActive;   // result collection phase
  } strobe_t;

endpackage

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WIDTH  = 32,
  parameter int SLOTS  = 14,
  parameter int CONSTS = 2,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [2:0]        uopKind,
  input  logic [1:0]        uopMath,
  input  logic              uopMod,
  input  logic              uopSrcBank,
  input  logic [SLOT_W-1:0] uopSrcA,
  input  logic [SLOT_W-1:0] uopSrcB,
  input  logic              uopDstBank,
  input  logic [SLOT_W-1:0] uopDstA,
  input  logic [SLOT_W-1:0] uopDstB,
  output kind_t             kindQ,
  output logic              wordLast,
  output logic              uopErr,
  output logic              rdBank,
  output logic [SLOT_W-1:0] rdSlotA,
  output logic [SLOT_W-1:0] rdSlotB,
  output logic [WORD_W-1:0] rdWord,
  input  logic [WIDTH-1:0]  rdDataA,
  input  logic [WIDTH-1:0]  rdDataB,
  output logic              wrEn,
  output logic              wrBank,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [WORD_W-1:0] wrWord,
  output logic [WIDTH-1:0]  wrData,
  output logic [WORD_W-1:0] memRdWord,
  input  logic [WIDTH-1:0]  memRdData,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrWord,
  output logic [WIDTH-1:0]  memWrData,
  output logic              engOpValid,
  output logic              engFirst,
  output logic [1:0]        engMath,
  output logic              engMod,
  output logic [WORD_W-1:0] engWord,
  output logic [WIDTH-1:0]  engOpA,
  output logic [WIDTH-1:0]  engOpB,
  input  logic              engRspValid,
  input  logic [WIDTH-1:0]  engRspData
);

  logic [1:0]        mathQ;
  logic              modQ, srcBankQ, dstBankQ, errQ;
  logic [SLOT_W-1:0] srcAQ, srcBQ, dstAQ, dstBQ, srcSel, dstSel;
  logic [WORD_W-1:0] cnt;
  logic              badDst, dstConst;
  kind_t             kindIn;

  assign kindIn = kind_t'(uopKind);
  assign badDst = (kindIn != K_STORE) &&
                  ((int'(uopDstA) < CONSTS) ||
                   ((kindIn == K_MOVE2) && (int'(uopDstB) < CONSTS)));

  always_ff @(posedge clk) begin
    if (rst) begin
      kindQ    <= K_MOVE;
      mathQ    <= '0;
      modQ     <= 1'b0;
      srcBankQ <= 1'b0;
      dstBankQ <= 1'b0;
      srcAQ    <= '0;
      srcBQ    <= '0;
      dstAQ    <= '0;
      dstBQ    <= '0;
      errQ     <= 1'b0;
      cnt      <= '0;
    end else begin
      if (stb.capture) begin
        kindQ    <= kindIn;
        mathQ    <= uopMath;
        modQ     <= uopMod;
        srcBankQ <= uopSrcBank;
        dstBankQ <= uopDstBank;
        srcAQ    <= uopSrcA;
        srcBQ    <= uopSrcB;
        dstAQ    <= uopDstA;
        dstBQ    <= uopDstB;
        errQ     <= badDst;
      end
      if (stb.capture || stb.cntClr) cnt <= '0;
      else if (stb.cntInc)           cnt <= cnt + 1'b1;
    end
  end

  assign wordLast = (cnt == WORD_W'(WORDS - 1));
  assign srcSel   = stb.second ? srcBQ : srcAQ;
  assign dstSel   = stb.second ? dstBQ : dstAQ;
  assign dstConst = int'(dstSel) < CONSTS;
  assign uopErr   = errQ;

  // bank side
  assign rdBank  = srcBankQ;
  assign rdSlotA = srcSel;
  assign rdSlotB = srcBQ;
  assign rdWord  = cnt;
  assign wrEn    = ((stb.copyActive && kindQ != K_STORE) ||
                    (stb.rspActive && engRspValid)) && !dstConst;
  assign wrBank  = dstBankQ;
  assign wrSlot  = dstSel;
  assign wrWord  = cnt;
  assign wrData  = stb.rspActive     ? engRspData :
                   (kindQ == K_LOAD) ? memRdData  : rdDataA;

  // external memory side
  assign memRdWord = cnt;
  assign memWrEn   = stb.copyActive && kindQ == K_STORE;
  assign memWrWord = cnt;
  assign memWrData = rdDataA;

  // engine side
  assign engOpValid = stb.sendActive;
  assign engFirst   = stb.sendActive && cnt == '0;
  assign engMath    = mathQ;
  assign engMod     = modQ;
  assign engWord    = cnt;
  assign engOpA     = rdDataA;
  assign engOpB     = rdDataB;

endmodule

// File: rtl/uop_control.sv
module uop_control
  import uop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       uopValid,
  input  logic [2:0] uopKind,
  output logic       uopReady,
  input  kind_t      kindQ,
  input  logic       wordLast,
  input  logic       engRspValid,
  output strobe_t    stb
);

  typedef enum logic [1:0] {S_IDLE, S_COPY, S_SEND, S_WAIT} state_t;

  state_t state, nextState;
  logic   secondQ, secondNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      secondQ <= 1'b0;
    end else begin
      state   <= nextState;
      secondQ <= secondNext;
    end
  end

  always_comb begin
    stb        = '0;
    stb.second = secondQ;
    nextState  = state;
    secondNext = secondQ;
    uopReady   = (state == S_IDLE);
    case (state)
      S_IDLE: if (uopValid) begin
        stb.capture = 1'b1;
        secondNext  = 1'b0;
        nextState   = (kind_t'(uopKind) == K_CALC) ? S_SEND : S_COPY;
      end
      S_COPY: begin
        stb.copyActive = 1'b1;
        stb.cntInc     = 1'b1;
        if (wordLast) begin
          stb.cntClr = 1'b1;
          if (kindQ == K_MOVE2 && !secondQ) secondNext = 1'b1;
          else                              nextState  = S_IDLE;
        end
      end
      S_SEND: begin
        stb.sendActive = 1'b1;
        stb.cntInc     = 1'b1;
        if (wordLast) begin
          stb.cntClr = 1'b1;
          nextState  = S_WAIT;
        end
      end
      S_WAIT: begin
        stb.rspActive = 1'b1;
        stb.cntInc    = engRspValid;
        if (engRspValid && wordLast) begin
          stb.cntClr = 1'b1;
          nextState  = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/uop_dispatch.sv
module uop_dispatch
  import uop_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WIDTH  = 32,
  parameter int SLOTS  = 14,
  parameter int CONSTS = 2,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uopValid,
  output logic              uopReady,
  input  logic [2:0]        uopKind,
  input  logic [1:0]        uopMath,
  input  logic              uopMod,
  input  logic              uopSrcBank,
  input  logic [SLOT_W-1:0] uopSrcA,
  input  logic [SLOT_W-1:0] uopSrcB,
  input  logic              uopDstBank,
  input  logic [SLOT_W-1:0] uopDstA,
  input  logic [SLOT_W-1:0] uopDstB,
  output logic              uopErr,
  output logic              rdBank,
  output logic [SLOT_W-1:0] rdSlotA,
  output logic [SLOT_W-1:0] rdSlotB,
  output logic [WORD_W-1:0] rdWord,
  input  logic [WIDTH-1:0]  rdDataA,
  input  logic [WIDTH-1:0]  rdDataB,
  output logic              wrEn,
  output logic              wrBank,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [WORD_W-1:0] wrWord,
  output logic [WIDTH-1:0]  wrData,
  output logic [WORD_W-1:0] memRdWord,
  input  logic [WIDTH-1:0]  memRdData,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrWord,
  output logic [WIDTH-1:0]  memWrData,
  output logic              engOpValid,
  output logic              engFirst,
  output logic [1:0]        engMath,
  output logic              engMod,
  output logic [WORD_W-1:0] engWord,
  output logic [WIDTH-1:0]  engOpA,
  output logic [WIDTH-1:0]  engOpB,
  input  logic              engRspValid,
  input  logic [WIDTH-1:0]  engRspData
);

  strobe_t stb;
  kind_t   kindQ;
  logic    wordLast;

  uop_control u_ctrl (
    .clk(clk), .rst(rst), .uopValid(uopValid), .uopKind(uopKind),
    .uopReady(uopReady), .kindQ(kindQ), .wordLast(wordLast),
    .engRspValid(engRspValid), .stb(stb)
  );

  uop_datapath #(.WORDS(WORDS), .WIDTH(WIDTH), .SLOTS(SLOTS), .CONSTS(CONSTS)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .uopKind(uopKind), .uopMath(uopMath), .uopMod(uopMod),
    .uopSrcBank(uopSrcBank), .uopSrcA(uopSrcA), .uopSrcB(uopSrcB),
    .uopDstBank(uopDstBank), .uopDstA(uopDstA), .uopDstB(uopDstB),
    .kindQ(kindQ), .wordLast(wordLast), .uopErr(uopErr),
    .rdBank(rdBank), .rdSlotA(rdSlotA), .rdSlotB(rdSlotB), .rdWord(rdWord),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrBank(wrBank), .wrSlot(wrSlot), .wrWord(wrWord), .wrData(wrData),
    .memRdWord(memRdWord), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrWord(memWrWord), .memWrData(memWrData),
    .engOpValid(engOpValid), .engFirst(engFirst), .engMath(engMath), .engMod(engMod),
    .engWord(engWord), .engOpA(engOpA), .engOpB(engOpB),
    .engRspValid(engRspValid), .engRspData(engRspData)
  );

endmodule

// File: rtl/uop_dispatch_chk.sv
module uop_dispatch_chk #(
  parameter int SLOTS  = 14,
  parameter int CONSTS = 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              uopValid,
  input logic              uopReady,
  input logic              uopErr,
  input logic              wrEn,
  input logic [SLOT_W-1:0] wrSlot,
  input logic              memWrEn,
  input logic              engOpValid
);

  // R9
  const_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> int'(wrSlot) >= CONSTS);

  // R8
  busy_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> !uopReady);

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (uopValid && uopReady) |=> !uopReady);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !uopReady |=> $stable(uopErr));

  // R6
  store_excl_chk: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> !wrEn);

  // R7
  eng_busy_chk: assert property (@(posedge clk) disable iff (rst)
    engOpValid |-> (!uopReady && !wrEn && !memWrEn));

endmodule

bind uop_dispatch uop_dispatch_chk #(.SLOTS(SLOTS), .CONSTS(CONSTS)) u_chk (
  .clk(clk), .rst(rst), .uopValid(uopValid), .uopReady(uopReady),
  .uopErr(uopErr), .wrEn(wrEn), .wrSlot(wrSlot), .memWrEn(memWrEn),
  .engOpValid(engOpValid)
);

// File: tb/uop_dispatch_bench.sv
module uop_dispatch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int WID = 32;
  localparam int EW  = W * WID;
  localparam logic [511:0] PMOD = (512'd1 << 255) - 512'd19;

  typedef struct packed {
    logic [2:0] kind;
    logic [1:0] math;
    logic       modSel;
    logic       srcBank;
    logic [3:0] srcA;
    logic [3:0] srcB;
    logic       dstBank;
    logic [3:0] dstA;
    logic [3:0] dstB;
    logic       expErr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 2'd0, 1'b0, 1'b0, 4'd0,  4'd0, 1'b0, 4'd4,  4'd0, 1'b0}, // load LO T_1
    '{3'd1, 2'd0, 1'b0, 1'b0, 4'd4,  4'd4, 1'b1, 4'd4,  4'd4, 1'b0}, // dual move LO->HI
    '{3'd4, 2'd2, 1'b1, 1'b0, 4'd4,  4'd4, 1'b1, 4'd5,  4'd0, 1'b0}, // mul 2p
    '{3'd4, 2'd0, 1'b0, 1'b1, 4'd5,  4'd4, 1'b0, 4'd2,  4'd0, 1'b0}, // add p
    '{3'd4, 2'd1, 1'b0, 1'b0, 4'd2,  4'd4, 1'b0, 4'd3,  4'd0, 1'b0}, // sub p
    '{3'd0, 2'd0, 1'b0, 1'b1, 4'd5,  4'd0, 1'b0, 4'd6,  4'd0, 1'b0}, // move HI->LO
    '{3'd1, 2'd0, 1'b0, 1'b0, 4'd2,  4'd3, 1'b0, 4'd3,  4'd2, 1'b0}, // dual move swap order
    '{3'd0, 2'd0, 1'b0, 1'b0, 4'd2,  4'd0, 1'b1, 4'd0,  4'd0, 1'b1}, // move to const
    '{3'd1, 2'd0, 1'b0, 1'b0, 4'd3,  4'd6, 1'b0, 4'd7,  4'd1, 1'b1}, // half to const
    '{3'd4, 2'd2, 1'b0, 1'b0, 4'd6,  4'd1, 1'b0, 4'd0,  4'd0, 1'b1}, // calc to const
    '{3'd4, 2'd1, 1'b1, 1'b1, 4'd4,  4'd5, 1'b1, 4'd13, 4'd0, 1'b0}, // sub 2p
    '{3'd3, 2'd0, 1'b0, 1'b1, 4'd13, 4'd0, 1'b0, 4'd0,  4'd0, 1'b0}, // store HI X100
    '{3'd2, 2'd0, 1'b0, 1'b0, 4'd0,  4'd0, 1'b1, 4'd1,  4'd0, 1'b1}, // load to const
    '{3'd4, 2'd2, 1'b0, 1'b0, 4'd7,  4'd7, 1'b0, 4'd7,  4'd0, 1'b0}, // mul in place
    '{3'd3, 2'd0, 1'b0, 1'b0, 4'd7,  4'd0, 1'b0, 4'd0,  4'd0, 1'b0}  // store LO T_1011
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uopValid = 1'b0;
  logic [2:0] uopKind = '0;
  logic [1:0] uopMath = '0;
  logic uopMod = 1'b0, uopSrcBank = 1'b0, uopDstBank = 1'b0;
  logic [3:0] uopSrcA = '0, uopSrcB = '0, uopDstA = '0, uopDstB = '0;
  logic uopReady, uopErr;
  logic rdBank, wrEn, wrBank, memWrEn, engOpValid, engFirst, engMod, engRspValid;
  logic [3:0] rdSlotA, rdSlotB, wrSlot;
  logic [2:0] rdWord, wrWord, memRdWord, memWrWord, engWord;
  logic [1:0] engMath;
  logic [WID-1:0] rdDataA, rdDataB, wrData, memRdData, memWrData, engOpA, engOpB, engRspData;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_dispatch #(.WORDS(W), .WIDTH(WID)) u_uop_dispatch (
    .clk(clk), .rst(rst), .uopValid(uopValid), .uopReady(uopReady),
    .uopKind(uopKind), .uopMath(uopMath), .uopMod(uopMod),
    .uopSrcBank(uopSrcBank), .uopSrcA(uopSrcA), .uopSrcB(uopSrcB),
    .uopDstBank(uopDstBank), .uopDstA(uopDstA), .uopDstB(uopDstB),
    .uopErr(uopErr), .rdBank(rdBank), .rdSlotA(rdSlotA), .rdSlotB(rdSlotB),
    .rdWord(rdWord), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrBank(wrBank), .wrSlot(wrSlot), .wrWord(wrWord), .wrData(wrData),
    .memRdWord(memRdWord), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrWord(memWrWord), .memWrData(memWrData),
    .engOpValid(engOpValid), .engFirst(engFirst), .engMath(engMath), .engMod(engMod),
    .engWord(engWord), .engOpA(engOpA), .engOpB(engOpB),
    .engRspValid(engRspValid), .engRspData(engRspData)
  );

  // ---------------- models of the surroundings ----------------
  function automatic logic [WID-1:0] initWord(int b, int s, int w);
    if (s == 0) return '0;
    if (s == 1) return (w == 0) ? 32'd1 : 32'd0;
    return 32'h9E3779B9 * (s * 16 + b * 8 + w + 1);
  endfunction

  function automatic logic [WID-1:0] memWord(int w);
    return 32'hC0DE0F00 ^ (32'h01234567 * (w + 3));
  endfunction

  function automatic logic [EW-1:0] memElem();
    logic [EW-1:0] v;
    for (int w = 0; w < W; w++) v[w*WID +: WID] = memWord(w);
    return v;
  endfunction

  function automatic logic [EW-1:0] modOp(logic [1:0] m, logic md,
                                          logic [EW-1:0] a, logic [EW-1:0] b);
    logic [511:0] n, r;
    n = md ? (PMOD * 2) : PMOD;
    case (m)
      2'd0:    r = ({256'b0, a} + {256'b0, b}) % n;
      2'd1:    r = ({256'b0, a} + 4 * n - {256'b0, b}) % n;
      default: r = ({256'b0, a} * {256'b0, b}) % n;
    endcase
    return r[EW-1:0];
  endfunction

  logic [WID-1:0] bankMem [0:1][0:15][0:W-1];
  logic [WID-1:0] storeMem [0:W-1];

  assign rdDataA   = bankMem[rdBank][rdSlotA][rdWord];
  assign rdDataB   = bankMem[rdBank][rdSlotB][rdWord];
  assign memRdData = memWord(int'(memRdWord));

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 16; s++)
          for (int w = 0; w < W; w++) bankMem[b][s][w] <= initWord(b, s, w);
    end else if (wrEn) begin
      bankMem[wrBank][wrSlot][wrWord] <= wrData;
    end
    if (memWrEn) storeMem[memWrWord] <= memWrData;
  end

  // stub arithmetic engine
  logic [WID-1:0] eA [0:W-1];
  logic [WID-1:0] eB [0:W-1];
  logic [EW-1:0]  packA, packB, rspVal;
  logic [1:0]     eMath;
  logic           eMod, rspOn, tick;
  logic [2:0]     rspIdx;
  int             rspDelay, expIdx;
  int             stubBad = 0;
  int             firstSeen = 0;

  always_comb begin
    for (int w = 0; w < W; w++) begin
      packA[w*WID +: WID] = eA[w];
      packB[w*WID +: WID] = eB[w];
    end
  end

  assign engRspValid = rspOn && tick;
  assign engRspData  = rspVal[int'(rspIdx)*WID +: WID];

  always @(posedge clk) begin
    if (rst) begin
      rspDelay <= 0; rspOn <= 1'b0; tick <= 1'b0; rspIdx <= '0; expIdx <= 0;
    end else begin
      if (engOpValid) begin
        eA[engWord] <= engOpA;
        eB[engWord] <= engOpB;
        eMath <= engMath;
        eMod  <= engMod;
        if (int'(engWord) != expIdx || engFirst != (engWord == 3'd0)) stubBad <= stubBad + 1;
        expIdx <= (expIdx == W - 1) ? 0 : expIdx + 1;
        if (engFirst) firstSeen <= firstSeen + 1;
        if (int'(engWord) == W - 1) rspDelay <= 3;
      end else if (rspDelay > 1) begin
        rspDelay <= rspDelay - 1;
      end else if (rspDelay == 1) begin
        rspDelay <= 0;
        rspVal   <= modOp(eMath, eMod, packA, packB);
        rspOn    <= 1'b1;
        tick     <= 1'b0;
        rspIdx   <= '0;
      end
      if (rspOn) begin
        tick <= ~tick;
        if (engRspValid) begin
          rspIdx <= rspIdx + 1'b1;
          if (int'(rspIdx) == W - 1) rspOn <= 1'b0;
        end
      end
    end
  end

  // ---------------- reference and checks ----------------
  int total = 0;
  int bad = 0;
  logic [EW-1:0] refB [0:1][0:15];
  logic [EW-1:0] expStore;

  task automatic check(bit ok, string tag, logic [EW-1:0] act, logic [EW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] bankElem(int b, int s);
    logic [EW-1:0] v;
    for (int w = 0; w < W; w++) v[w*WID +: WID] = bankMem[b][s][w];
    return v;
  endfunction

  function automatic string kindTag(logic [2:0] k);
    case (k)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic refInit();
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < W; w++) refB[b][s][w*WID +: WID] = initWord(b, s, w);
  endtask

  task automatic refApply(vec_t v);
    case (v.kind)
      3'd0: if (v.dstA >= 2) refB[v.dstBank][v.dstA] = refB[v.srcBank][v.srcA];
      3'd1: begin
        if (v.dstA >= 2) refB[v.dstBank][v.dstA] = refB[v.srcBank][v.srcA];
        if (v.dstB >= 2) refB[v.dstBank][v.dstB] = refB[v.srcBank][v.srcB];
      end
      3'd2: if (v.dstA >= 2) refB[v.dstBank][v.dstA] = memElem();
      3'd3: expStore = refB[v.srcBank][v.srcA];
      default: if (v.dstA >= 2)
        refB[v.dstBank][v.dstA] = modOp(v.math, v.modSel,
                                        refB[v.srcBank][v.srcA], refB[v.srcBank][v.srcB]);
    endcase
  endtask

  task automatic issue(vec_t v, output int busy);
    @(negedge clk);
    uopKind = v.kind; uopMath = v.math; uopMod = v.modSel;
    uopSrcBank = v.srcBank; uopSrcA = v.srcA; uopSrcB = v.srcB;
    uopDstBank = v.dstBank; uopDstA = v.dstA; uopDstB = v.dstB;
    uopValid = 1'b1;
    @(negedge clk);
    uopValid = 1'b0;
    busy = 0;
    while (!uopReady) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic compareBanks(string tag);
    bit ok = 1'b1;
    logic [EW-1:0] a = '0, e = '0;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 14; s++)
        if (ok && bankElem(b, s) !== refB[b][s]) begin
          ok = 1'b0; a = bankElem(b, s); e = refB[b][s];
        end
    check(ok, tag, a, e);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int busy;
    int calcs;
    calcs = 0;
    refInit();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(uopReady && !wrEn && !memWrEn && !engOpValid && !uopErr, "R1 during reset",
          {uopReady, wrEn, memWrEn, engOpValid, uopErr}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    check(uopReady && !wrEn && !memWrEn && !engOpValid && !uopErr, "R1 after reset",
          {uopReady, wrEn, memWrEn, engOpValid, uopErr}, 5'b10000);

    // vector table, each op issued as soon as ready returns (R8 back-to-back)
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i], busy);
      refApply(VEC[i]);
      if (VEC[i].kind == 3'd4) calcs++;
      compareBanks({kindTag(VEC[i].kind), "/R2 bank contents"});
      check(uopErr == VEC[i].expErr, "R9 error flag", uopErr, VEC[i].expErr);
      if (VEC[i].kind != 3'd4)
        check(busy == ((VEC[i].kind == 3'd1) ? 2 * W : W), "R8 busy cycles",
              busy, (VEC[i].kind == 3'd1) ? 2 * W : W);
      if (VEC[i].kind == 3'd3) begin
        logic [EW-1:0] sv;
        for (int w = 0; w < W; w++) sv[w*WID +: WID] = storeMem[w];
        check(sv === expStore, "R6 stored element", sv, expStore);
      end
    end

    // R10: operand stream order and first marker
    check(stubBad == 0, "R10 operand word order", stubBad, 0);
    check(firstSeen == calcs, "R10 first marker count", firstSeen, calcs);

    // R1: reset abandons an op in flight and clears the error flag
    begin
      vec_t v;
      v = VEC[7];
      issue(v, busy);
      check(uopErr == 1'b1, "R9 flag before reset", uopErr, 1);
      @(negedge clk);
      uopKind = 3'd0; uopSrcBank = 1'b0; uopSrcA = 4'd3;
      uopDstBank = 1'b1; uopDstA = 4'd2; uopValid = 1'b1;
      @(negedge clk);
      uopValid = 1'b0;
      repeat (2) @(negedge clk);
      check(!uopReady, "R8 busy mid-op", uopReady, 0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(uopReady && !uopErr && !wrEn, "R1 reset mid-op",
            {uopReady, uopErr, wrEn}, 3'b100);
      repeat (3 * W) @(negedge clk);
      check(!wrEn && uopReady, "R1 no resumed op", {wrEn, uopReady}, 2'b01);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule